// File: doc/BRIEF.md
# Sign-Magnitude Threshold Comparator with Pickup and Reset Timers

This block combines two 8-bit sign-magnitude arguments into one operating value, either their sum or their difference, and compares that value against a programmable threshold. The operand select is live: flipping it changes the operating value and the comparison in the same cycle. The comparison direction can be set to trip above or below the threshold. It can act on the signed operating value or on its magnitude. A hysteresis band sets the level at which a tripped comparison releases.

Two outputs report the result. The pickup output follows the comparison directly. The operate output follows a qualified version of it: it asserts once the condition has held for a programmable number of timing ticks, and it releases once the condition has been absent for another programmable number of ticks. A block input holds the element idle and clears its timers. The saturated operating value is also driven out in sign-magnitude form, whatever the magnitude mode.

Top module: `smc_top`

## Requirements
- R1: `opval_o` is A+B or A−B of the sign-magnitude arguments (bit 7 = sign, set for negative; bits 6..0 = magnitude), saturated to ±127. A zero result is encoded 0x00, and an argument of 0x80 counts as zero.
- R2: `add_sel` = 0 selects A−B and 1 selects A+B. A change shows on `opval_o` and `pickup_o` in the same cycle.
- R3: With `abs_mode` = 1 the comparison uses the magnitude of the operating value. `opval_o` is unaffected by `abs_mode`.
- R4: With `dir_under` = 0, an idle element picks up when the compared value is strictly greater than `pick_lvl`. Equality does not pick up.
- R5: With `dir_under` = 1, an idle element picks up when the compared value is strictly less than `pick_lvl`. Equality does not pick up.
- R6: Once picked up, the element stays picked up until the compared value reaches the dropout level. The dropout level is `pick_lvl` − `hyst` when over and `pick_lvl` + `hyst` when under. Reaching dropout exactly counts as dropped out.
- R7: `operate_o` rises on the clock edge of the (`pkp_dly`+1)-th consecutive `tick_en` cycle with the condition present. A delay of 0 means the first such tick. Any cycle without the condition restarts the count.
- R8: `operate_o` falls on the clock edge of the (`rst_dly`+1)-th consecutive `tick_en` cycle with the condition absent. Any cycle with the condition restarts the count.
- R9: While `block_in` is 1, `pickup_o` is 0 at once, `operate_o` is 0 from the next edge, and both timers are cleared.
- R10: In the cycle in which `block_in` returns to 0 with the condition present, `pickup_o` is 1. The pickup delay is counted from that cycle.
- R11: While `rst_n` is 0, `pickup_o` and `operate_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing tick enable for the delay counters |
| arg_a | input | 8 | Argument A, sign-magnitude |
| arg_b | input | 8 | Argument B, sign-magnitude |
| add_sel | input | 1 | 0: A−B, 1: A+B |
| abs_mode | input | 1 | 1: compare the magnitude of the operating value |
| dir_under | input | 1 | 0: trip above threshold, 1: trip below |
| pick_lvl | input | 10 | Pickup threshold, two's complement |
| hyst | input | 10 | Hysteresis width, two's complement |
| pkp_dly | input | 16 | Pickup delay in ticks |
| rst_dly | input | 16 | Reset delay in ticks |
| block_in | input | 1 | Forces the element inactive |
| opval_o | output | 8 | Saturated operating value, sign-magnitude |
| pickup_o | output | 1 | Immediate comparison result |
| operate_o | output | 1 | Delayed, qualified comparison result |

## Verification
The hardest state to reach is a value lying inside the hysteresis band while the element is already picked up. The same inputs then give opposite answers depending on history. The stimulus first drives the value past the threshold, then walks it down one step at a time to exactly the dropout level. Block release is reached in the same way: the trip condition is held while `block_in` is asserted, so that the restart of the timers can be seen at the moment of release. A behavioural reference model in the bench follows all of this cycle by cycle, including a long stretch of random operands, ticks and short delays.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic {
    DIR_OVER  = 1'b0,
    DIR_UNDER = 1'b1
  } dir_e;
endpackage

// File: rtl/smc_arith.sv
module smc_arith #(
  parameter int ARG_W  = 8,
  parameter int CALC_W = ARG_W + 2
) (
  input  logic [ARG_W-1:0]         arg_a,
  input  logic [ARG_W-1:0]         arg_b,
  input  logic                     add_sel,
  input  logic                     abs_mode,
  output logic [ARG_W-1:0]         op_sm,
  output logic signed [CALC_W-1:0] eff_o
);
  localparam int MAG_W   = ARG_W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int PAD_W   = CALC_W - MAG_W;

  logic signed [CALC_W-1:0] mag_a, mag_b, val_a, val_b, sum, sum_abs;
  logic [MAG_W-1:0]         sat_mag;

  always_comb begin
    mag_a   = $signed({{PAD_W{1'b0}}, arg_a[MAG_W-1:0]});
    mag_b   = $signed({{PAD_W{1'b0}}, arg_b[MAG_W-1:0]});
    val_a   = arg_a[ARG_W-1] ? -mag_a : mag_a;
    val_b   = arg_b[ARG_W-1] ? -mag_b : mag_b;
    sum     = add_sel ? (val_a + val_b) : (val_a - val_b);
    sum_abs = (sum < 0) ? -sum : sum;
    eff_o   = abs_mode ? sum_abs : sum;
    sat_mag = (sum_abs > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : sum_abs[MAG_W-1:0];
    op_sm   = {(sum < 0), sat_mag};
  end

  // R1
  always_comb begin
    opval_no_negzero_chk: assert (!(op_sm[ARG_W-1] && (op_sm[MAG_W-1:0] == '0)));
  end
endmodule

// File: rtl/smc_detect.sv
module smc_detect
  import smc_pkg::*;
#(
  parameter int CALC_W = 10,
  parameter int THR_W  = 10,
  parameter int CMP_W  = THR_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     block_i,
  input  dir_e                     dir_i,
  input  logic signed [CALC_W-1:0] eff_i,
  input  logic signed [THR_W-1:0]  pick_lvl,
  input  logic signed [THR_W-1:0]  hyst,
  output logic                     cond_o
);
  logic signed [CMP_W-1:0] eff_x, pk_x, hy_x, drop_lvl, use_lvl;
  logic picked_q, picked_d;

  always_comb begin
    eff_x    = CMP_W'(eff_i);
    pk_x     = CMP_W'(pick_lvl);
    hy_x     = CMP_W'(hyst);
    drop_lvl = (dir_i == DIR_UNDER) ? (pk_x + hy_x) : (pk_x - hy_x);
    use_lvl  = picked_q ? drop_lvl : pk_x;
    cond_o   = (dir_i == DIR_UNDER) ? (eff_x < use_lvl) : (eff_x > use_lvl);
    picked_d = block_i ? 1'b0 : cond_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) picked_q <= 1'b0;
    else        picked_q <= picked_d;
  end

  // R6
  drop_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (picked_q && !cond_o) |=> !picked_q);
endmodule

// File: rtl/smc_timer.sv
module smc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cond_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] pk_dly,
  input  logic [CNT_W-1:0] rs_dly,
  output logic             op_o
);
  logic             op_q, op_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    op_d  = op_q;
    cnt_d = cnt_q;
    if (block_i) begin
      op_d  = 1'b0;
      cnt_d = '0;
    end else if (!op_q) begin
      if (!cond_i) cnt_d = '0;
      else if (tick_i) begin
        if (cnt_q >= pk_dly) begin
          op_d  = 1'b1;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cond_i) cnt_d = '0;
      else if (tick_i) begin
        if (cnt_q >= rs_dly) begin
          op_d  = 1'b0;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      op_q  <= op_d;
      cnt_q <= cnt_d;
    end
  end

  assign op_o = op_q;

  // R7
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_q) |-> $past(tick_i && cond_i && !block_i));
  // R8
  fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(op_q) && !$past(block_i)) |-> $past(tick_i && !cond_i));
  // R9
  block_clears_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |=> !op_q);
endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
#(
  parameter int ARG_W = 8,
  parameter int THR_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [ARG_W-1:0] arg_a,
  input  logic [ARG_W-1:0] arg_b,
  input  logic             add_sel,
  input  logic             abs_mode,
  input  logic             dir_under,
  input  logic [THR_W-1:0] pick_lvl,
  input  logic [THR_W-1:0] hyst,
  input  logic [CNT_W-1:0] pkp_dly,
  input  logic [CNT_W-1:0] rst_dly,
  input  logic             block_in,
  output logic [ARG_W-1:0] opval_o,
  output logic             pickup_o,
  output logic             operate_o
);
  localparam int CALC_W = ARG_W + 2;

  logic signed [CALC_W-1:0] eff;
  logic cond;
  dir_e dir;

  assign dir = dir_under ? DIR_UNDER : DIR_OVER;

  smc_arith #(.ARG_W(ARG_W), .CALC_W(CALC_W)) arith_i (
    .arg_a(arg_a), .arg_b(arg_b), .add_sel(add_sel), .abs_mode(abs_mode),
    .op_sm(opval_o), .eff_o(eff)
  );

  smc_detect #(.CALC_W(CALC_W), .THR_W(THR_W)) detect_i (
    .clk(clk), .rst_n(rst_n), .block_i(block_in), .dir_i(dir), .eff_i(eff),
    .pick_lvl($signed(pick_lvl)), .hyst($signed(hyst)), .cond_o(cond)
  );

  smc_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .cond_i(cond),
    .block_i(block_in), .pk_dly(pkp_dly), .rs_dly(rst_dly), .op_o(operate_o)
  );

  assign pickup_o = cond & ~block_in & rst_n;

  // R9
  always_comb begin
    if (block_in) blocked_no_pickup_chk: assert (!pickup_o);
  end
endmodule

// File: tb/smc_top_tb_top.sv
module smc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic [7:0] arg_a = '0, arg_b = '0;
  logic add_sel = 0, abs_mode = 0, dir_under = 0, block_in = 0;
  int   pk_i = 0, hy_i = 0, pkd_i = 0, rsd_i = 0;
  logic [7:0] opval_o;
  logic pickup_o, operate_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  int m_pick = 0, m_op = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .arg_a(arg_a), .arg_b(arg_b),
    .add_sel(add_sel), .abs_mode(abs_mode), .dir_under(dir_under),
    .pick_lvl(pk_i[9:0]), .hyst(hy_i[9:0]), .pkp_dly(pkd_i[15:0]),
    .rst_dly(rsd_i[15:0]), .block_in(block_in),
    .opval_o(opval_o), .pickup_o(pickup_o), .operate_o(operate_o)
  );

  function automatic int sm2i(logic [7:0] x);
    return x[7] ? -int'(x[6:0]) : int'(x[6:0]);
  endfunction

  function automatic logic [7:0] i2sm(int v);
    int m = (v < 0) ? -v : v;
    if (m > 127) m = 127;
    return {(v < 0), m[6:0]};
  endfunction

  function automatic int raw_val();
    return add_sel ? sm2i(arg_a) + sm2i(arg_b) : sm2i(arg_a) - sm2i(arg_b);
  endfunction

  function automatic int exp_cond();
    int s = raw_val();
    int e = abs_mode ? ((s < 0) ? -s : s) : s;
    int lvl = pk_i;
    if (m_pick != 0) lvl = dir_under ? pk_i + hy_i : pk_i - hy_i;
    return dir_under ? int'(e < lvl) : int'(e > lvl);
  endfunction

  task automatic chk(string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, expv);
    end
  endtask

  task automatic step();
    int c;
    #1;
    c = exp_cond();
    chk("opval", int'(opval_o), int'(i2sm(raw_val())));
    chk("pickup", int'(pickup_o), (rst_n && !block_in) ? c : 0);
    chk("operate", int'(operate_o), m_op);
    if (!rst_n || block_in) begin
      m_pick = 0; m_op = 0; m_cnt = 0;
    end else begin
      m_pick = c;
      if (m_op == 0) begin
        if (c == 0) m_cnt = 0;
        else if (tick_en) begin
          if (m_cnt >= pkd_i) begin m_op = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end else begin
        if (c != 0) m_cnt = 0;
        else if (tick_en) begin
          if (m_cnt >= rsd_i) begin m_op = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic settle();
    arg_a = 8'h00; arg_b = 8'h00; add_sel = 0; abs_mode = 0; dir_under = 0;
    pk_i = 100; hy_i = 0; pkd_i = 0; rsd_i = 0; tick_en = 1; block_in = 0;
    steps(3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R11 reset holds outputs low even with a trip condition present
    cur_req = "R11";
    arg_a = i2sm(90); pk_i = 10; tick_en = 1;
    steps(3);
    chk("pickup in reset", int'(pickup_o), 0);
    chk("operate in reset", int'(operate_o), 0);
    rst_n = 1;
    settle();

    // R1 saturation and zero encoding
    cur_req = "R1";
    arg_a = i2sm(100); arg_b = i2sm(-100); add_sel = 0; #1;
    chk("sat pos", int'(opval_o), 8'h7F); step();
    arg_a = i2sm(-100); arg_b = i2sm(100); #1;
    chk("sat neg", int'(opval_o), 8'hFF); step();
    arg_a = i2sm(5); arg_b = i2sm(5); #1;
    chk("zero", int'(opval_o), 8'h00); step();
    arg_a = 8'h80; arg_b = 8'h00; #1;
    chk("neg zero", int'(opval_o), 8'h00); step();

    // R2 live operand select
    cur_req = "R2";
    arg_a = i2sm(20); arg_b = i2sm(7); add_sel = 0; #1;
    chk("diff", int'(opval_o), 13); step();
    add_sel = 1; #1;
    chk("sum", int'(opval_o), 27); step();

    // R3 magnitude mode
    cur_req = "R3";
    settle();
    pk_i = 10; arg_a = i2sm(-50); arg_b = 0; add_sel = 0; abs_mode = 0; #1;
    chk("signed no pickup", int'(pickup_o), 0); step();
    abs_mode = 1; #1;
    chk("abs pickup", int'(pickup_o), 1);
    chk("opval keeps sign", int'(opval_o), 8'hB2); step();

    // R4 over threshold, equality not tripped
    cur_req = "R4";
    settle();
    pk_i = 50; arg_a = i2sm(50); #1;
    chk("equal", int'(pickup_o), 0); step();
    arg_a = i2sm(51); #1;
    chk("above", int'(pickup_o), 1); step();

    // R5 under threshold
    cur_req = "R5";
    settle();
    dir_under = 1; pk_i = -20; arg_a = i2sm(-20); #1;
    chk("equal", int'(pickup_o), 0); step();
    arg_a = i2sm(-21); #1;
    chk("below", int'(pickup_o), 1); step();

    // R6 hysteresis band, over: dropout at 30
    cur_req = "R6";
    settle();
    pk_i = 40; hy_i = 10; pkd_i = 1000;
    arg_a = i2sm(45); step();
    arg_a = i2sm(31); #1;
    chk("in band", int'(pickup_o), 1); step();
    arg_a = i2sm(30); #1;
    chk("at dropout", int'(pickup_o), 0); step();
    arg_a = i2sm(35); #1;
    chk("band after drop", int'(pickup_o), 0); step();
    // R6 under: pickup below -10, dropout at -5
    dir_under = 1; pk_i = -10; hy_i = 5;
    arg_a = i2sm(-11); step();
    arg_a = i2sm(-6); #1;
    chk("under band", int'(pickup_o), 1); step();
    arg_a = i2sm(-5); #1;
    chk("under dropout", int'(pickup_o), 0); step();

    // R7 pickup delay of 3 and of 0
    cur_req = "R7";
    settle();
    pk_i = 10; pkd_i = 3; arg_a = i2sm(20);
    steps(3);
    chk("before delay", int'(operate_o), 0);
    step();
    chk("after delay", int'(operate_o), 1);
    settle();
    pk_i = 10; pkd_i = 0; arg_a = i2sm(20);
    step();
    chk("zero delay", int'(operate_o), 1);
    // R7 sparse ticks
    settle();
    pk_i = 10; pkd_i = 1; arg_a = i2sm(20);
    for (int i = 0; i < 6; i++) begin tick_en = i[0]; step(); end

    // R8 reset delay of 2
    cur_req = "R8";
    rsd_i = 2; tick_en = 1; arg_a = 0;
    steps(2);
    chk("hold", int'(operate_o), 1);
    step();
    chk("released", int'(operate_o), 0);

    // R9 block
    cur_req = "R9";
    settle();
    pk_i = 10; pkd_i = 0; arg_a = i2sm(20); step();
    block_in = 1; #1;
    chk("pickup blocked", int'(pickup_o), 0); step();
    chk("operate blocked", int'(operate_o), 0);
    steps(4);

    // R10 release with condition present, delay 2
    cur_req = "R10";
    pkd_i = 2; block_in = 0; #1;
    chk("pickup at release", int'(pickup_o), 1);
    steps(2);
    chk("timing from release", int'(operate_o), 0);
    step();
    chk("operate after delay", int'(operate_o), 1);

    // random stretch covering R6 R7 R8 R9 under the model
    cur_req = "RAND R6";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) arg_a = 8'($urandom);
      if ($urandom_range(0, 3) == 0) arg_b = 8'($urandom);
      if ($urandom_range(0, 15) == 0) add_sel = ~add_sel;
      if ($urandom_range(0, 31) == 0) abs_mode = ~abs_mode;
      if ($urandom_range(0, 63) == 0) dir_under = ~dir_under;
      if ($urandom_range(0, 63) == 0) pk_i = $urandom_range(0, 200) - 100;
      if ($urandom_range(0, 63) == 0) hy_i = $urandom_range(0, 30);
      if ($urandom_range(0, 63) == 0) pkd_i = $urandom_range(0, 5);
      if ($urandom_range(0, 63) == 0) rsd_i = $urandom_range(0, 5);
      tick_en = ($urandom_range(0, 2) != 0);
      block_in = ($urandom_range(0, 40) == 0);
      step();
    end
    finish_run();
  end
endmodule